// File: doc/BRIEF.md
# Programmable Read Latency Pipeline

This block is the data-output end of a synchronous DRAM read path. Each cycle it may receive one internal read word with a valid flag. It presents that word on a 16-bit output bus after a programmed number of clocks, one to three. Two byte-lane enables show which halves of the bus are being driven. A lane whose enable is low is treated as floating, and its data lines read as zero.

Separate upper and lower mask inputs can blank either byte of the bus. They act at their own fixed delay, which does not depend on the data latency. A precharge or burst-stop input ends the read: any word that would otherwise reach the bus three or more clocks after the stop is discarded. A new read issued after the stop runs normally.

The latency setting can only be changed while nothing is in flight. This keeps the pipeline slots free of collisions.

Top module: `read_lat_pipe`

## Requirements
- R1: A word presented with `rd_valid` high in cycle c appears on `dq_out`, with its byte enables high, in cycle c+L. L is the latency in effect during cycle c. The `lat_sel` value written is the latency in clocks.
- R2: A write of `lat_sel` through `lat_wr` takes effect from the next cycle only when three things hold: `lat_sel` is between 1 and 3, `rd_valid` is low in that cycle, and no earlier word is still waiting to appear in a later cycle. Any other write leaves the latency unchanged.
- R3: `mask_hi` or `mask_lo` sampled high in cycle c forces the matching byte off in cycle c+2. That byte's enable is low and its lines are zero. `mask_hi` controls bits 15:8 and `mask_lo` controls bits 7:0.
- R4: `cut` sampled high in cycle c discards every word launched in cycle c or earlier that would appear in cycle c+3 or later. If no read follows, both enables are low from cycle c+3 onward.
- R5: Reads in consecutive cycles appear in consecutive cycles. A read issued on any cycle after a cut, including the very next one, appears at the programmed latency.
- R6: Each byte enable is high exactly in the cycles that carry a valid word whose byte is not masked. A byte whose enable is low reads as zero.
- R7: A synchronous reset empties every stage, drives both enables low and the bus to zero, clears the mask delay, and sets the latency to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lat_wr | input | 1 | Request to load a new latency |
| lat_sel | input | 2 | Requested latency in clocks (1 to 3) |
| rd_valid | input | 1 | An internal read word is present this cycle |
| rd_data | input | 16 | Internal read word |
| mask_hi | input | 1 | Upper byte mask |
| mask_lo | input | 1 | Lower byte mask |
| cut | input | 1 | Precharge or burst stop |
| dq_out | output | 16 | Output data, zero on lanes that float |
| oe_hi | output | 1 | Upper byte driven |
| oe_lo | output | 1 | Lower byte driven |

## Verification
A slot that holds a word in the wrong position shows up at the ports as a word arriving one cycle early or late. This is seen at the first read after the latency is set, within three cycles. A latency register that takes a write while words are pending shows up as a shifted arrival on the next read. A stale mask stage or a missed cut shows up as an enable high in a cycle where the bench expects the byte to float. This is seen two or three cycles after the mask or cut is sampled. The bench compares data and both enables in every cycle against a schedule it keeps per output cycle, so any such drift is caught in the first cycle it reaches the bus.

// File: rtl/rlp_pkg.sv
package rlp_pkg;
  // Fixed protocol delays, counted in clocks from the sampling cycle.
  localparam int MASK_LAT = 2;
  localparam int CUT_LAT  = 3;

  typedef struct packed {
    logic hi;
    logic lo;
  } lane_mask_t;
endpackage

// File: rtl/rlp_delay.sv
module rlp_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_regs
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
          stg[0] <= din;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign dout = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/rlp_lat_ctrl.sv
module rlp_lat_ctrl #(
  parameter int MAX_LAT = 3,
  parameter int LW      = 2,
  parameter int DEF_LAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [LW-1:0] sel,
  input  logic          busy,
  output logic [LW-1:0] lat_q
);
  logic take;
  assign take = wr && !busy && (sel != '0) && (sel <= LW'(MAX_LAT));

  always_ff @(posedge clk) begin
    if (rst)       lat_q <= LW'(DEF_LAT);
    else if (take) lat_q <= sel;
  end

  p_lat_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && busy) |=> $stable(lat_q));

  p_lat_range_r2: assert property (@(posedge clk) disable iff (rst)
    (lat_q != '0) && (lat_q <= LW'(MAX_LAT)));
endmodule

// File: rtl/rlp_slot_pipe.sv
module rlp_slot_pipe #(
  parameter int DW      = 16,
  parameter int MAX_LAT = 3,
  parameter int LW      = 2,
  parameter int CUT_LAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [DW-1:0] word,
  input  logic [LW-1:0] lat,
  input  logic          cut,
  output logic          head_v,
  output logic [DW-1:0] head_d,
  output logic          pending
);
  // Slot j holds a word that reaches the bus j cycles after the current one.
  localparam int NS = MAX_LAT - 1;

  logic [NS:1]   v_vec;
  logic [DW-1:0] d_arr [NS:1];

  generate
    for (genvar j = 1; j <= NS; j++) begin : g_slot
      logic          v_q, v_n, up_v, load;
      logic [DW-1:0] d_q, d_n, up_d;

      if (j == NS) begin : g_last
        assign up_v = 1'b0;
        assign up_d = '0;
      end else begin : g_inner
        assign up_v = v_vec[j+1];
        assign up_d = d_arr[j+1];
      end

      assign load = launch && (lat == LW'(j + 1));

      always_comb begin
        v_n = load ? 1'b1 : up_v;
        d_n = load ? word : up_d;
        if (cut && (j >= CUT_LAT - 1)) v_n = 1'b0;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else begin
          v_q <= v_n;
          d_q <= d_n;
        end
      end

      assign v_vec[j] = v_q;
      assign d_arr[j] = d_q;
    end
  endgenerate

  assign head_v  = (launch && (lat == LW'(1))) || v_vec[1];
  assign head_d  = (launch && (lat == LW'(1))) ? word : d_arr[1];
  assign pending = |v_vec;
endmodule

// File: rtl/rlp_out_stage.sv
module rlp_out_stage
  import rlp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          head_v,
  input  logic [DW-1:0] head_d,
  input  lane_mask_t    mask_d,
  output logic [DW-1:0] dq_out,
  output logic          oe_hi,
  output logic          oe_lo
);
  localparam int HALF = DW / 2;

  logic drive_hi, drive_lo;
  assign drive_hi = head_v && !mask_d.hi;
  assign drive_lo = head_v && !mask_d.lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out <= '0;
      oe_hi  <= 1'b0;
      oe_lo  <= 1'b0;
    end else begin
      oe_hi             <= drive_hi;
      oe_lo             <= drive_lo;
      dq_out[DW-1:HALF] <= drive_hi ? head_d[DW-1:HALF] : '0;
      dq_out[HALF-1:0]  <= drive_lo ? head_d[HALF-1:0]  : '0;
    end
  end
endmodule

// File: rtl/read_lat_pipe.sv
module read_lat_pipe
  import rlp_pkg::*;
#(
  parameter int DW      = 16,
  parameter int MAX_LAT = 3,
  parameter int DEF_LAT = 3,
  parameter int LW      = $clog2(MAX_LAT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lat_wr,
  input  logic [LW-1:0] lat_sel,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic          mask_hi,
  input  logic          mask_lo,
  input  logic          cut,
  output logic [DW-1:0] dq_out,
  output logic          oe_hi,
  output logic          oe_lo
);
  localparam int HALF = DW / 2;

  logic [LW-1:0] lat_q;
  logic          pending, busy, head_v;
  logic [DW-1:0] head_d;
  lane_mask_t    mask_in, mask_d;

  assign busy    = rd_valid || pending;
  assign mask_in = '{hi: mask_hi, lo: mask_lo};

  rlp_lat_ctrl #(.MAX_LAT(MAX_LAT), .LW(LW), .DEF_LAT(DEF_LAT)) u_lat (
    .clk(clk), .rst(rst), .wr(lat_wr), .sel(lat_sel), .busy(busy), .lat_q(lat_q)
  );

  rlp_slot_pipe #(.DW(DW), .MAX_LAT(MAX_LAT), .LW(LW), .CUT_LAT(CUT_LAT)) u_slots (
    .clk(clk), .rst(rst), .launch(rd_valid), .word(rd_data), .lat(lat_q),
    .cut(cut), .head_v(head_v), .head_d(head_d), .pending(pending)
  );

  rlp_delay #(.W(2), .DEPTH(MASK_LAT - 1)) u_mdly (
    .clk(clk), .rst(rst), .din(mask_in), .dout(mask_d)
  );

  rlp_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .head_v(head_v), .head_d(head_d), .mask_d(mask_d),
    .dq_out(dq_out), .oe_hi(oe_hi), .oe_lo(oe_lo)
  );

  p_lat1_data_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(rd_valid) && ($past(lat_q) == LW'(1))
     && !$past(mask_lo, 2))
    |-> (oe_lo && (dq_out[HALF-1:0] == $past(rd_data[HALF-1:0]))));

  p_mask_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(mask_hi, 2)) |-> !oe_hi);

  p_mask_lo_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(mask_lo, 2)) |-> !oe_lo);

  p_cut_float_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && $past(cut, 3)
     && !$past(rd_valid, 2) && !$past(rd_valid))
    |-> (!oe_hi && !oe_lo));
endmodule

// File: tb/sim_read_lat_pipe.sv
`timescale 1ns/1ps
module sim_read_lat_pipe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lat_wr = 1'b0;
  logic [1:0]  lat_sel = 2'd0;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_data = 16'h0;
  logic        mask_hi = 1'b0, mask_lo = 1'b0, cut = 1'b0;
  logic [15:0] dq_out;
  logic        oe_hi, oe_lo;

  always #2 clk = ~clk;

  read_lat_pipe u0 (
    .clk(clk), .rst(rst), .lat_wr(lat_wr), .lat_sel(lat_sel), .rd_valid(rd_valid),
    .rd_data(rd_data), .mask_hi(mask_hi), .mask_lo(mask_lo), .cut(cut),
    .dq_out(dq_out), .oe_hi(oe_hi), .oe_lo(oe_lo)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Schedule indexed by output cycle modulo 16.
  bit          sv [16];
  logic [15:0] sd [16];
  bit          mh [16];
  bit          ml [16];
  int          L = 3;
  int          t = 0;

  function automatic void model_clear();
    for (int i = 0; i < 16; i++) begin
      sv[i] = 0; sd[i] = '0; mh[i] = 0; ml[i] = 0;
    end
    L = 3;
    t = 0;
  endfunction

  function automatic logic [16:0] exp_out(int c);
    bit eh, el;
    logic [15:0] d;
    eh = sv[c % 16] && !mh[(c + 14) % 16];
    el = sv[c % 16] && !ml[(c + 14) % 16];
    d  = {eh ? sd[c % 16][15:8] : 8'h00, el ? sd[c % 16][7:0] : 8'h00};
    return {eh, el, d[15:1], d[0]} ;
  endfunction

  task automatic check_now(input string req);
    logic [16:0] e;
    bit eh, el;
    logic [15:0] ed;
    e  = exp_out(t);
    eh = sv[t % 16] && !mh[(t + 14) % 16];
    el = sv[t % 16] && !ml[(t + 14) % 16];
    ed = e[15:0];
    n_checks++;
    if (dq_out !== ed || oe_hi !== eh || oe_lo !== el) begin
      n_fail++;
      $display("FAIL %s cycle %0d: dq=%h oe=%b%b, expected dq=%h oe=%b%b",
               req, t, dq_out, oe_hi, oe_lo, ed, eh, el);
    end
    sv[t % 16] = 0;
  endtask

  task automatic step(input string req, input bit rv, input logic [15:0] rd,
                      input bit mhi, input bit mlo, input bit ct,
                      input bit lw, input int ls);
    bit pend;
    int newL;
    @(negedge clk);
    check_now(req);
    rd_valid = rv; rd_data = rd; mask_hi = mhi; mask_lo = mlo;
    cut = ct; lat_wr = lw; lat_sel = ls[1:0];
    pend = 0;
    for (int o = t + 1; o <= t + 3; o++) if (sv[o % 16]) pend = 1;
    newL = L;
    if (lw && !rv && !pend && ls >= 1 && ls <= 3) newL = ls;
    if (rv) begin
      sv[(t + L) % 16] = 1;
      sd[(t + L) % 16] = rd;
    end
    mh[t % 16] = mhi;
    ml[t % 16] = mlo;
    if (ct) sv[(t + 3) % 16] = 0;
    L = newL;
    t++;
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) step(req, 0, 16'h0, 0, 0, 0, 0, 0);
  endtask

  task automatic set_lat(input string req, input int v);
    step(req, 0, 16'h0, 0, 0, 0, 1, v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; rd_valid = 0; cut = 0; lat_wr = 0; mask_hi = 0; mask_lo = 0;
    @(negedge clk);
    n_checks++;
    if (dq_out !== 16'h0 || oe_hi !== 1'b0 || oe_lo !== 1'b0) begin
      n_fail++;
      $display("FAIL R7 reset: dq=%h oe=%b%b, expected dq=0000 oe=00", dq_out, oe_hi, oe_lo);
    end
    rst = 0;
    model_clear();
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_clear();
    repeat (3) @(posedge clk);
    do_reset();

    // R7: reset state, then R1 at the default latency of 3.
    idle("R7", 2);
    step("R1", 1, 16'hA1B2, 0, 0, 0, 0, 0);
    idle("R1", 4);

    // R1 and R2: latency 1, then latency 2, written while idle.
    set_lat("R2", 1);
    step("R1", 1, 16'h1357, 0, 0, 0, 0, 0);
    step("R1", 1, 16'h2468, 0, 0, 0, 0, 0);
    idle("R1", 3);
    set_lat("R2", 2);
    step("R1", 1, 16'hC0DE, 0, 0, 0, 0, 0);
    idle("R1", 3);

    // R2: writes while a word is pending, with a same-cycle read, or with value 0 are all ignored.
    step("R2", 1, 16'h0F0F, 0, 0, 0, 0, 0);
    set_lat("R2", 3);
    idle("R2", 3);
    step("R2", 1, 16'hBEEF, 0, 0, 0, 1, 1);
    idle("R2", 3);
    set_lat("R2", 0);
    step("R2", 1, 16'h7777, 0, 0, 0, 0, 0);
    idle("R2", 3);

    // R3 and R6: byte masks over a stream at latency 1.
    set_lat("R3", 1);
    step("R3", 1, 16'h1111, 1, 0, 0, 0, 0);
    step("R3", 1, 16'h2222, 0, 1, 0, 0, 0);
    step("R3", 1, 16'h3333, 1, 1, 0, 0, 0);
    step("R3", 1, 16'h4444, 0, 0, 0, 0, 0);
    step("R6", 1, 16'h5555, 0, 0, 0, 0, 0);
    idle("R3", 4);

    // R4: cut in the middle of a burst at latency 3.
    set_lat("R4", 3);
    step("R4", 1, 16'hAA01, 0, 0, 0, 0, 0);
    step("R4", 1, 16'hAA02, 0, 0, 0, 0, 0);
    step("R4", 1, 16'hAA03, 0, 0, 1, 0, 0);
    idle("R4", 6);

    // R5: back-to-back reads, and a read on the cycle right after a cut.
    set_lat("R5", 2);
    step("R5", 1, 16'hB001, 0, 0, 0, 0, 0);
    step("R5", 1, 16'hB002, 0, 0, 0, 0, 0);
    step("R5", 1, 16'hB003, 0, 0, 1, 0, 0);
    step("R5", 1, 16'hB004, 0, 0, 0, 0, 0);
    step("R5", 1, 16'hB005, 0, 0, 0, 0, 0);
    idle("R5", 4);

    // R6: random mix of reads, masks, cuts and latency writes.
    for (int i = 0; i < 800; i++) begin
      step("R6", ($urandom % 4) != 0, 16'($urandom), ($urandom % 6) == 0,
           ($urandom % 6) == 0, ($urandom % 25) == 0, ($urandom % 12) == 0,
           int'($urandom % 4));
    end
    idle("R6", 4);

    // R7: reset with words in flight empties the pipe and restores latency 3.
    set_lat("R7", 1);
    step("R7", 1, 16'hD00D, 0, 0, 0, 0, 0);
    step("R7", 1, 16'hD00E, 0, 0, 0, 0, 0);
    do_reset();
    idle("R7", 3);
    step("R7", 1, 16'hFACE, 0, 0, 0, 0, 0);
    idle("R7", 5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule